// File: doc/BRIEF.md
# Processor Cluster Control Register Block

This block is the control and status register file for a cluster of four processor cores. Software reaches it through a 32-bit APB-style slave port with zero wait states. It holds a reset vector base address for each core, two configuration words, bus QoS levels, snoop control bits and a power-control word. The low four bits of the power-control word are per-core power-down requests.

Each core's power-down request is combined with that core's wait-for-interrupt input. The result is a per-core signal toward the power manager, and a registered copy of each request goes to a per-core power-status output. A single interrupt line reports bad bus accesses. It is built from a write-one-to-clear status bit and a mask bit. The mask bit is changed only through separate enable and disable registers.

A small bus-phase state machine follows the transfer. It has three states. IDLE goes to SETUP when select is high and enable is low. SETUP goes to ACCESS when select and enable are both high, and that SETUP-to-ACCESS transition is the cycle in which the access takes effect. ACCESS goes back to SETUP when a new transfer starts at once, and otherwise returns to IDLE.

Top module: `ccr_top`

## Requirements
- R1: After reset, reads return these values: 0x0000_0F0F for config 0 (0x20), 0x000F_000F for QoS (0x60), 0xFFFF_0000 for every vector low word, 1 for the mask (0x14), and 0 for every other register. The `irq_o`, `wfi_o` and `pstat_o` outputs are low.
- R2: The vector low word of core n sits at 0x40+8n and stores bits [31:2]; bits [1:0] read 0. The high word sits at 0x44+8n and stores bits [7:0]; its other bits read 0.
- R3: A write to the mask register at 0x14 leaves the mask unchanged.
- R4: Writing 1 in bit 0 of 0x18 clears mask bit 0, and writing 1 in bit 0 of 0x1C sets it. Both registers read 0.
- R5: `irq_o` is high exactly when status bit 0 is set and mask bit 0 is clear.
- R6: Writing 1 in bit 0 of the status register at 0x10 clears status bit 0. Writing 0 leaves it unchanged.
- R7: `wfi_o[i]` equals power-down request bit i AND `wfi_i[i]`. It follows `wfi_i` with no clock delay.
- R8: The power-control register at 0x90 stores bits [3:0] (per-core requests), bit 16 and bit 17. All other bits read 0.
- R9: `pstat_o[i]` takes the new value of request bit i from the clock edge that commits the write to 0x90.
- R10: The power-status register at 0x94 is read-only. It reads 0, and writes to it are ignored.
- R11: An access is bad if its offset is unmapped or not word-aligned, or if it is a write whose byte strobes are not all set. A bad access sets status bit 0 and changes no register. It returns `pslverr_o` high only when bit 0 of the error-control register at 0x00 is set.
- R12: Only these writable bits are stored: mask 0x0F0F_0F0F for config 0 at 0x20, 0x3000_000F for config 1 at 0x24, 0x000F_000F for QoS at 0x60, 0x0000_0011 for snoop at 0x80, and bit 0 for error control at 0x00. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W (8) | Byte offset |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Write byte strobes |
| prdata | output | 32 | Read data, valid in the access cycle |
| pready | output | 1 | Always high (no wait states) |
| pslverr | output | 1 | Error response for a bad access when reporting is on |
| wfi_i | input | NCORE (4) | Per-core wait-for-interrupt inputs |
| wfi_o | output | NCORE (4) | Per-core gated WFI toward the power manager |
| pstat_o | output | NCORE (4) | Per-core power-status outputs |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default parameters: NCORE = 4 and ADDR_W = 8. The 8-bit offset space reaches every mapped register, the whole vector window of four pairs, and unmapped or misaligned offsets on both sides of each region. With four cores, all sixteen combinations of request and WFI can be driven, and the edges of the vector window (core 0 low word, core 3 high word, 0x60 just past the window) can be hit on purpose. Random writes mixed with random WFI inputs run the gating, mask and status logic through their sequences alongside directed checks of the reset values and the error response.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACCESS} bus_phase_t;

    localparam int OFS_ERR   = 'h00;
    localparam int OFS_STAT  = 'h10;
    localparam int OFS_MASK  = 'h14;
    localparam int OFS_UNMSK = 'h18;
    localparam int OFS_MSK   = 'h1C;
    localparam int OFS_CFGA  = 'h20;
    localparam int OFS_CFGB  = 'h24;
    localparam int OFS_VEC   = 'h40;
    localparam int OFS_QOS   = 'h60;
    localparam int OFS_SNP   = 'h80;
    localparam int OFS_PCTL  = 'h90;
    localparam int OFS_PSTS  = 'h94;

    localparam logic [31:0] KEEP_CFGA = 32'h0F0F_0F0F;
    localparam logic [31:0] KEEP_CFGB = 32'h3000_000F;
    localparam logic [31:0] KEEP_QOS  = 32'h000F_000F;
    localparam logic [31:0] KEEP_SNP  = 32'h0000_0011;
    localparam logic [31:0] KEEP_VLO  = 32'hFFFF_FFFC;
    localparam logic [31:0] KEEP_VHI  = 32'h0000_00FF;

    localparam logic [31:0] INIT_CFGA = 32'h0000_0F0F;
    localparam logic [31:0] INIT_QOS  = 32'h000F_000F;
    localparam logic [31:0] INIT_VLO  = 32'hFFFF_0000;
endpackage

// File: rtl/ccr_phase.sv
module ccr_phase
    import ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic go_o
);
    bus_phase_t cur, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= PH_IDLE;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        unique case (cur)
            PH_IDLE:   if (psel && !penable) nxt = PH_SETUP;
            PH_SETUP:  if (psel && penable)  nxt = PH_ACCESS;
                       else if (!psel)       nxt = PH_IDLE;
            PH_ACCESS: nxt = (psel && !penable) ? PH_SETUP : PH_IDLE;
            default:   nxt = PH_IDLE;
        endcase
    end

    always_comb go_o = (cur == PH_SETUP) && psel && penable;
endmodule

// File: rtl/ccr_irq.sv
module ccr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic raise_i,
    input  logic clr_i,
    input  logic unmask_i,
    input  logic mask_i,
    output logic stat_q,
    output logic mask_q,
    output logic irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
            mask_q <= 1'b1;
        end else begin
            stat_q <= raise_i | (stat_q & ~clr_i);
            if (mask_i)        mask_q <= 1'b1;
            else if (unmask_i) mask_q <= 1'b0;
        end
    end

    always_comb irq_o = stat_q & ~mask_q;
endmodule

// File: rtl/ccr_pwr.sv
module ccr_pwr #(
    parameter int NCORE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [NCORE-1:0] req_d,
    input  logic [NCORE-1:0] wfi_i,
    output logic [NCORE-1:0] req_q,
    output logic [NCORE-1:0] wfi_o,
    output logic [NCORE-1:0] pstat_o
);
    for (genvar c = 0; c < NCORE; c++) begin : g_core
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_q[c]   <= 1'b0;
                pstat_o[c] <= 1'b0;
            end else if (we_i) begin
                req_q[c] <= req_d[c];
                if (req_d[c] != req_q[c]) pstat_o[c] <= req_d[c];
            end
        end
        always_comb wfi_o[c] = req_q[c] & wfi_i[c];
    end
endmodule

// File: rtl/ccr_top.sv
module ccr_top
    import ccr_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic [3:0]        pstrb,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [NCORE-1:0]  wfi_i,
    output logic [NCORE-1:0]  wfi_o,
    output logic [NCORE-1:0]  pstat_o,
    output logic              irq_o
);
    localparam int IDX_W   = (NCORE > 1) ? $clog2(NCORE) : 1;
    localparam int VEC_END = OFS_VEC + 8 * NCORE;

    logic              go, hit, bad, wr_go;
    logic [31:0]       rd_mux;
    logic [ADDR_W-1:0] rel;
    logic [IDX_W-1:0]  vidx;
    logic              stat_q, mask_q, err_en;
    logic [NCORE-1:0]  req_q;
    logic [1:0]        pctl_hi;
    logic [31:0]       cfga, cfgb, qos, snp;
    logic [31:0]       vlo [NCORE];
    logic [31:0]       vhi [NCORE];

    ccr_phase u_phase (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .go_o(go));

    always_comb begin
        rel  = paddr - ADDR_W'(OFS_VEC);
        vidx = rel[3 +: IDX_W];
        hit  = 1'b1;
        rd_mux = '0;
        case (int'(paddr))
            OFS_ERR:   rd_mux = {31'b0, err_en};
            OFS_STAT:  rd_mux = {31'b0, stat_q};
            OFS_MASK:  rd_mux = {31'b0, mask_q};
            OFS_UNMSK, OFS_MSK, OFS_PSTS: rd_mux = '0;
            OFS_CFGA:  rd_mux = cfga;
            OFS_CFGB:  rd_mux = cfgb;
            OFS_QOS:   rd_mux = qos;
            OFS_SNP:   rd_mux = snp;
            OFS_PCTL:  rd_mux = 32'(req_q) | {14'b0, pctl_hi, 16'b0};
            default: begin
                if (int'(paddr) >= OFS_VEC && int'(paddr) < VEC_END && rel[1:0] == 2'b00)
                    rd_mux = rel[2] ? vhi[vidx] : vlo[vidx];
                else
                    hit = 1'b0;
            end
        endcase
        bad   = !hit || (pwrite && pstrb != 4'hF);
        wr_go = go && pwrite && !bad;
    end

    always_comb begin
        pready  = 1'b1;
        prdata  = (go && !pwrite && !bad) ? rd_mux : '0;
        pslverr = go && bad && err_en;
    end

    function automatic logic wr_at(input int ofs);
        return wr_go && int'(paddr) == ofs;
    endfunction

    ccr_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .raise_i(go && bad),
        .clr_i(wr_at(OFS_STAT) && pwdata[0]),
        .unmask_i(wr_at(OFS_UNMSK) && pwdata[0]),
        .mask_i(wr_at(OFS_MSK) && pwdata[0]),
        .stat_q(stat_q), .mask_q(mask_q), .irq_o(irq_o)
    );

    ccr_pwr #(.NCORE(NCORE)) u_pwr (
        .clk(clk), .rst_n(rst_n),
        .we_i(wr_at(OFS_PCTL)), .req_d(pwdata[NCORE-1:0]),
        .wfi_i(wfi_i), .req_q(req_q), .wfi_o(wfi_o), .pstat_o(pstat_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_en  <= 1'b0;
            cfga    <= INIT_CFGA;
            cfgb    <= '0;
            qos     <= INIT_QOS;
            snp     <= '0;
            pctl_hi <= '0;
        end else begin
            if (wr_at(OFS_ERR))  err_en  <= pwdata[0];
            if (wr_at(OFS_CFGA)) cfga    <= pwdata & KEEP_CFGA;
            if (wr_at(OFS_CFGB)) cfgb    <= pwdata & KEEP_CFGB;
            if (wr_at(OFS_QOS))  qos     <= pwdata & KEEP_QOS;
            if (wr_at(OFS_SNP))  snp     <= pwdata & KEEP_SNP;
            if (wr_at(OFS_PCTL)) pctl_hi <= pwdata[17:16];
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_vec
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vlo[c] <= INIT_VLO;
                vhi[c] <= '0;
            end else begin
                if (wr_at(OFS_VEC + 8 * c))     vlo[c] <= pwdata & KEEP_VLO;
                if (wr_at(OFS_VEC + 8 * c + 4)) vhi[c] <= pwdata & KEEP_VHI;
            end
        end
    end
endmodule

// File: rtl/ccr_chk.sv
module ccr_chk #(
    parameter int NCORE  = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic              go,
    input logic              bad,
    input logic              pslverr,
    input logic [NCORE-1:0]  wfi_i,
    input logic [NCORE-1:0]  wfi_o,
    input logic [NCORE-1:0]  pstat_o,
    input logic              irq_o,
    input logic              stat_q,
    input logic              mask_q
);
    assert_wfi_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wfi_o == (pstat_o & wfi_i));

    assert_pstat_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && pwrite && !bad && paddr == ADDR_W'('h90)) |=> pstat_o == $past(pwdata[NCORE-1:0]));

    assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat_q && !mask_q));

    assert_mask_no_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && pwrite && paddr == ADDR_W'('h14)) |=> $stable(mask_q));

    assert_err_only_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (psel && penable));

    assert_bad_sets_stat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bad) |=> stat_q);
endmodule

bind ccr_top ccr_chk #(.NCORE(NCORE), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .go(go), .bad(bad), .pslverr(pslverr),
    .wfi_i(wfi_i), .wfi_o(wfi_o), .pstat_o(pstat_o), .irq_o(irq_o),
    .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/sim_ccr_top.sv
`timescale 1ns/1ps
module sim_ccr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = 4'hF;
    logic [31:0] prdata;
    logic        pready, pslverr, irq_o;
    logic [3:0]  wfi_i = '0, wfi_o, pstat_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ccr_top u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .wfi_i(wfi_i), .wfi_o(wfi_o),
        .pstat_o(pstat_o), .irq_o(irq_o)
    );

    // bench model of the register state
    bit [31:0] m_err, m_cfga, m_cfgb, m_qos, m_snp, m_pctl;
    bit [31:0] m_vlo [4];
    bit [31:0] m_vhi [4];
    bit        m_stat, m_mask;

    task automatic model_reset();
        m_err = 0; m_cfga = 32'h0F0F; m_cfgb = 0; m_qos = 32'h000F000F;
        m_snp = 0; m_pctl = 0; m_stat = 0; m_mask = 1;
        for (int i = 0; i < 4; i++) begin m_vlo[i] = 32'hFFFF0000; m_vhi[i] = 0; end
    endtask

    function automatic bit mapped(input logic [7:0] a);
        if (a[1:0] != 2'b00) return 0;
        if (a >= 8'h40 && a < 8'h60) return 1;
        return a inside {8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24,
                         8'h60, 8'h80, 8'h90, 8'h94};
    endfunction

    function automatic bit [31:0] exp_read(input logic [7:0] a);
        if (a >= 8'h40 && a < 8'h60)
            return a[2] ? m_vhi[(a - 8'h40) >> 3] : m_vlo[(a - 8'h40) >> 3];
        case (a)
            8'h00: return m_err;
            8'h10: return {31'b0, m_stat};
            8'h14: return {31'b0, m_mask};
            8'h20: return m_cfga;
            8'h24: return m_cfgb;
            8'h60: return m_qos;
            8'h80: return m_snp;
            8'h90: return m_pctl;
            default: return 0;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        if (a >= 8'h40 && a < 8'h60) begin
            if (a[2]) m_vhi[(a - 8'h40) >> 3] = d & 32'hFF;
            else      m_vlo[(a - 8'h40) >> 3] = d & 32'hFFFFFFFC;
            return;
        end
        case (a)
            8'h00: m_err = d & 32'h1;
            8'h10: if (d[0]) m_stat = 0;
            8'h18: if (d[0]) m_mask = 0;
            8'h1C: if (d[0]) m_mask = 1;
            8'h20: m_cfga = d & 32'h0F0F0F0F;
            8'h24: m_cfgb = d & 32'h3000000F;
            8'h60: m_qos  = d & 32'h000F000F;
            8'h80: m_snp  = d & 32'h11;
            8'h90: m_pctl = d & 32'h0003000F;
            default: ;
        endcase
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        check({req, " irq"},   {31'b0, irq_o},   {31'b0, m_stat & ~m_mask});
        check({req, " pstat"}, {28'b0, pstat_o}, {28'b0, m_pctl[3:0]});
        check({req, " wfi"},   {28'b0, wfi_o},   {28'b0, m_pctl[3:0] & wfi_i});
    endtask

    // one bus transfer, checked against the model
    task automatic xfer(input string req, input bit wr, input logic [7:0] a,
                        input logic [31:0] d, input logic [3:0] s);
        bit        is_bad;
        bit [31:0] e_rd;
        bit        e_err;
        logic [31:0] rd;
        logic        er;
        is_bad = !mapped(a) || (wr && s != 4'hF);
        e_rd   = (wr || is_bad) ? 32'h0 : exp_read(a);
        e_err  = is_bad && m_err[0];
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
        @(negedge clk);
        penable = 1;
        #1; rd = prdata; er = pslverr;
        @(negedge clk);
        psel = 0; penable = 0;
        if (!wr) check({req, " rdata"}, rd, e_rd);
        check({req, " slverr"}, {31'b0, er}, {31'b0, e_err});
        if (is_bad) m_stat = 1;
        else if (wr) model_write(a, d);
        check_outs(req);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        logic [7:0] offs [14];
        offs = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24,
                 8'h40, 8'h5C, 8'h60, 8'h80, 8'h90, 8'h94, 8'h4C};
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state of outputs and registers
        check_outs("R1");
        xfer("R1 cfg0", 0, 8'h20, 0, 4'hF);
        xfer("R1 qos",  0, 8'h60, 0, 4'hF);
        xfer("R1 mask", 0, 8'h14, 0, 4'hF);
        for (int i = 0; i < 4; i++) begin
            xfer("R1 vlo", 0, 8'h40 + 8'(8 * i), 0, 4'hF);
            xfer("R1 vhi", 0, 8'h44 + 8'(8 * i), 0, 4'hF);
        end
        xfer("R1 stat", 0, 8'h10, 0, 4'hF);

        // R2: vector words, window edges
        xfer("R2 wr lo0", 1, 8'h40, 32'h1234_5677, 4'hF);
        xfer("R2 rd lo0", 0, 8'h40, 0, 4'hF);
        xfer("R2 wr hi3", 1, 8'h5C, 32'hFFFF_FFFF, 4'hF);
        xfer("R2 rd hi3", 0, 8'h5C, 0, 4'hF);

        // R12: masked stores
        xfer("R12 wr cfg0", 1, 8'h20, 32'hFFFF_FFFF, 4'hF);
        xfer("R12 rd cfg0", 0, 8'h20, 0, 4'hF);
        xfer("R12 wr cfg1", 1, 8'h24, 32'hFFFF_FFFF, 4'hF);
        xfer("R12 rd cfg1", 0, 8'h24, 0, 4'hF);
        xfer("R12 wr snp",  1, 8'h80, 32'hFFFF_FFFF, 4'hF);
        xfer("R12 rd snp",  0, 8'h80, 0, 4'hF);

        // R11: bad accesses, reporting off then on
        xfer("R11 unmapped off", 0, 8'h64, 0, 4'hF);
        check("R11 stat set", {31'b0, irq_o}, 32'h0);
        xfer("R11 rd stat", 0, 8'h10, 0, 4'hF);
        xfer("R11 err on", 1, 8'h00, 32'h1, 4'hF);
        xfer("R11 misaligned", 0, 8'h42, 0, 4'hF);
        xfer("R11 partial strobe", 1, 8'h20, 32'h0, 4'h3);
        xfer("R11 cfg0 kept", 0, 8'h20, 0, 4'hF);
        xfer("R11 past window", 0, 8'h70, 0, 4'hF);

        // R3, R4, R5, R6: mask and status path
        xfer("R3 direct mask wr", 1, 8'h14, 32'h0, 4'hF);
        xfer("R3 mask kept", 0, 8'h14, 0, 4'hF);
        xfer("R4 unmask", 1, 8'h18, 32'h1, 4'hF);
        check("R5 irq high", {31'b0, irq_o}, 32'h1);
        xfer("R4 unmask rd0", 0, 8'h18, 0, 4'hF);
        xfer("R6 w1c zero", 1, 8'h10, 32'h0, 4'hF);
        xfer("R6 w1c one", 1, 8'h10, 32'h1, 4'hF);
        xfer("R5 irq after clr", 0, 8'h10, 0, 4'hF);
        xfer("R4 mask", 1, 8'h1C, 32'h1, 4'hF);
        xfer("R4 mask rd0", 0, 8'h1C, 0, 4'hF);

        // R7, R8, R9, R10: power path
        xfer("R8 wr pctl", 1, 8'h90, 32'hFFFF_FFFF, 4'hF);
        xfer("R8 rd pctl", 0, 8'h90, 0, 4'hF);
        for (int w = 0; w < 16; w++) begin
            wfi_i = 4'(w);
            #1;
            check("R7 wfi comb", {28'b0, wfi_o}, {28'b0, m_pctl[3:0] & 4'(w)});
        end
        xfer("R9 wr pctl 5", 1, 8'h90, 32'h0000_0005, 4'hF);
        xfer("R10 wr psts", 1, 8'h94, 32'hFFFF_FFFF, 4'hF);
        xfer("R10 rd psts", 0, 8'h94, 0, 4'hF);

        // random mix
        for (int k = 0; k < 600; k++) begin
            logic [7:0]  a;
            logic [31:0] d;
            bit          wr;
            wfi_i = 4'($urandom);
            a  = ($urandom % 8 == 0) ? 8'($urandom) : offs[$urandom % 14];
            d  = $urandom;
            wr = 1'($urandom);
            xfer("R12 R8 R5 random", wr, a, d, ($urandom % 6 == 0) ? 4'($urandom) : 4'hF);
        end

        done = 1'b1;
        summary();
    end
endmodule